// File: doc/BRIEF.md
# Converter Monotonicity Staircase Stimulus

This block generates a repeating test pattern for checking that a digital-to-analog converter stays monotonic close to zero. The pattern starts with a run of zero samples. It then produces a symmetric square wave whose amplitude grows by one LSB per segment: first ±1, then ±2, and so on up to ±10. After the ±10 segment the pattern returns to zero and repeats. Every segment lasts ten square-wave periods. Each period is two halves, and each half holds a programmable number of samples.

Samples advance on a one-cycle sample-rate tick, nominally 352.8 kHz. Each sample is a 16-bit two's-complement code. The block shifts it out MSB-first on a serial data line that runs with its own bit clock. After the LSB it raises a latch strobe so the converter takes the new word once per sample. The current amplitude and code also appear on debug outputs so a monitor can follow the pattern.

Top module: `mono_stair_gen`

## Requirements
- R1: A synchronous active-high reset drives ser_data, ser_clk, ser_latch, dbg_code and dbg_amp to zero. The first sample after reset is the first sample of the zero segment.
- R2: The zero segment holds code 0x0000 for 10 periods. With H samples per half, that is 20·H samples.
- R3: The segment with amplitude k (1 to 10) repeats the following for 10 periods: H samples of +k, then H samples of −k in two's complement. So −1 is 0xFFFF and −10 is 0xFFF6.
- R4: After the ±10 segment the pattern restarts at the zero segment. One full cycle is 220·H samples.
- R5: half_len gives H. It is read at every tick, and a value of 0 acts as 1.
- R6: Each sample is shifted out MSB first as 16 rising edges of ser_clk. Each bit is valid on ser_data one system clock before its rising edge and stays valid through that edge.
- R7: After the LSB, ser_latch is high for exactly one bit-clock period (two system clocks), once per sample. ser_clk stays low while ser_latch is high.
- R8: dbg_code and dbg_amp change one clock after a tick and hold until the next tick. The serial frame starts one clock after that and lasts 34 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_tick | input | 1 | One-cycle pulse at the sample rate |
| half_len | input | HALF_W (8) | Samples per half-period (0 treated as 1) |
| ser_data | output | 1 | Serial sample data, MSB first |
| ser_clk | output | 1 | Bit clock, data taken on rising edge |
| ser_latch | output | 1 | Latch strobe after the LSB |
| dbg_amp | output | 4 | Amplitude of the current sample |
| dbg_code | output | 16 | Two's-complement code of the current sample |

## Verification
The assertions assume that sample ticks are single-cycle pulses at least 35 clocks apart, so every serial frame and its latch strobe finish before the next sample loads. They also assume half_len changes only while reset is held. The stimulus sends exactly one tick every 40 clocks and sets half_len before it releases reset. Within those limits the bench still covers a zero half length, a reset in the middle of a segment, and a full wrap from ±10 back to zero.

// File: rtl/mono_stair_pkg.sv
package mono_stair_pkg;

    localparam int CODE_W    = 16;
    localparam int MAX_AMP   = 10;
    localparam int AMP_W     = $clog2(MAX_AMP + 1);
    localparam int BIT_IDX_W = $clog2(CODE_W + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [AMP_W-1:0]  amp_t;

    // One staircase level: magnitude plus the half of the period it sits in
    typedef struct packed {
        amp_t amp;
        logic neg;
    } level_t;

    // Registered sample handed from the sequencer stage to the serializer
    typedef struct packed {
        code_t code;
        amp_t  amp;
    } sample_t;

    function automatic code_t level_to_code(level_t lv);
        code_t mag;
        mag = code_t'(lv.amp);
        return lv.neg ? (~mag + code_t'(1)) : mag;
    endfunction

endpackage

// File: rtl/stair_sequencer.sv
module stair_sequencer
    import mono_stair_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int SEG_PERIODS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [HALF_W-1:0] half_len,
    output level_t            level
);

    localparam int PER_W = (SEG_PERIODS > 1) ? $clog2(SEG_PERIODS) : 1;

    amp_t              amp_q;
    logic              neg_q;
    logic [PER_W-1:0]  per_q;
    logic [HALF_W-1:0] smp_q;
    logic [HALF_W-1:0] half_eff;
    logic              half_done;
    logic              seg_done;

    always_comb begin
        half_eff  = (half_len == '0) ? HALF_W'(1) : half_len;
        half_done = (smp_q >= half_eff - HALF_W'(1));
        seg_done  = (per_q == PER_W'(SEG_PERIODS - 1));
        level     = '{amp: amp_q, neg: neg_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_q <= '0;
            neg_q <= 1'b0;
            per_q <= '0;
            smp_q <= '0;
        end else if (tick) begin
            if (!half_done) begin
                smp_q <= smp_q + HALF_W'(1);
            end else begin
                smp_q <= '0;
                if (!neg_q) begin
                    neg_q <= 1'b1;
                end else begin
                    neg_q <= 1'b0;
                    if (!seg_done) begin
                        per_q <= per_q + PER_W'(1);
                    end else begin
                        per_q <= '0;
                        amp_q <= (amp_q == amp_t'(MAX_AMP)) ? '0 : amp_q + amp_t'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bit_serializer.sv
module bit_serializer
    import mono_stair_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t word,
    output logic  sdata,
    output logic  sclk,
    output logic  latch
);

    localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(CODE_W);

    logic                 busy_q;
    logic                 phase_q;
    logic [BIT_IDX_W-1:0] idx_q;
    code_t                shreg_q;
    logic                 in_data;

    always_comb begin
        in_data = busy_q && (idx_q < LAST_IDX);
        sdata   = in_data && shreg_q[CODE_W-1];
        sclk    = in_data && phase_q;
        latch   = busy_q && (idx_q == LAST_IDX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            idx_q   <= '0;
            shreg_q <= '0;
        end else if (load) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            idx_q   <= '0;
            shreg_q <= word;
        end else if (busy_q) begin
            phase_q <= ~phase_q;
            if (phase_q) begin
                if (idx_q == LAST_IDX) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q   <= idx_q + BIT_IDX_W'(1);
                    shreg_q <= {shreg_q[CODE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/mono_stair_gen.sv
module mono_stair_gen
    import mono_stair_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int SEG_PERIODS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_tick,
    input  logic [HALF_W-1:0] half_len,
    output logic              ser_data,
    output logic              ser_clk,
    output logic              ser_latch,
    output logic [AMP_W-1:0]  dbg_amp,
    output logic [CODE_W-1:0] dbg_code
);

    level_t  level;
    sample_t smp_q;
    logic    load_q;

    stair_sequencer #(
        .HALF_W      (HALF_W),
        .SEG_PERIODS (SEG_PERIODS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (sample_tick),
        .half_len (half_len),
        .level    (level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_q  <= '0;
            load_q <= 1'b0;
        end else begin
            load_q <= sample_tick;
            if (sample_tick) begin
                smp_q <= '{code: level_to_code(level), amp: level.amp};
            end
        end
    end

    bit_serializer u_ser (
        .clk   (clk),
        .rst   (rst),
        .load  (load_q),
        .word  (smp_q.code),
        .sdata (ser_data),
        .sclk  (ser_clk),
        .latch (ser_latch)
    );

    assign dbg_amp  = smp_q.amp;
    assign dbg_code = smp_q.code;

endmodule

// File: rtl/mono_stair_chk.sv
module mono_stair_chk
    import mono_stair_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sample_tick,
    input logic              ser_clk,
    input logic              ser_latch,
    input logic [AMP_W-1:0]  dbg_amp,
    input logic [CODE_W-1:0] dbg_code
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!ser_clk && !ser_latch && dbg_code == '0 && dbg_amp == '0));

    assert_amp_range_R3: assert property (@(posedge clk) disable iff (rst)
        dbg_amp <= amp_t'(MAX_AMP));

    assert_code_matches_amp_R3: assert property (@(posedge clk) disable iff (rst)
        (dbg_code == level_to_code('{amp: dbg_amp, neg: 1'b0})) ||
        (dbg_code == level_to_code('{amp: dbg_amp, neg: 1'b1})));

    assert_latch_no_sclk_R7: assert property (@(posedge clk) disable iff (rst)
        !(ser_latch && ser_clk));

    assert_latch_min_width_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_latch) |=> ser_latch);

    assert_latch_max_width_R7: assert property (@(posedge clk) disable iff (rst)
        (ser_latch && $past(ser_latch)) |=> !ser_latch);

    assert_code_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(sample_tick) |-> $stable(dbg_code));

endmodule

bind mono_stair_gen mono_stair_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_tick (sample_tick),
    .ser_clk     (ser_clk),
    .ser_latch   (ser_latch),
    .dbg_amp     (dbg_amp),
    .dbg_code    (dbg_code)
);

// File: tb/test_mono_stair_gen.sv
module test_mono_stair_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_tick = 1'b0;
    logic [7:0]  half_len = 8'd1;
    logic        ser_data, ser_clk, ser_latch;
    logic [3:0]  dbg_amp;
    logic [15:0] dbg_code;

    int n_checks = 0;
    int n_fail   = 0;

    // monitor storage
    logic [15:0] cap_word [0:1023];
    int          cap_bits [0:1023];
    int          cap_lew  [0:1023];
    int          n_cap = 0;
    logic [15:0] mon_shift = '0;
    int          mon_bits = 0;
    int          mon_lew = 0;
    logic        prev_sclk = 1'b0;
    logic        prev_le = 1'b0;

    always #2.5 clk = ~clk;

    mono_stair_gen i_mono_stair_gen (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .half_len    (half_len),
        .ser_data    (ser_data),
        .ser_clk     (ser_clk),
        .ser_latch   (ser_latch),
        .dbg_amp     (dbg_amp),
        .dbg_code    (dbg_code)
    );

    always @(negedge clk) begin
        if (ser_clk && !prev_sclk) begin
            mon_shift = {mon_shift[14:0], ser_data};
            mon_bits  = mon_bits + 1;
        end
        if (ser_latch) mon_lew = mon_lew + 1;
        if (ser_latch && !prev_le && n_cap < 1024) begin
            cap_word[n_cap] = mon_shift;
            cap_bits[n_cap] = mon_bits;
            mon_bits = 0;
        end
        if (!ser_latch && prev_le && n_cap < 1024) begin
            cap_lew[n_cap] = mon_lew;
            mon_lew = 0;
            n_cap = n_cap + 1;
        end
        prev_sclk = ser_clk;
        prev_le   = ser_latch;
    end

    function automatic int eff_half(int hl);
        return (hl == 0) ? 1 : hl;
    endfunction

    function automatic int exp_amp(int k, int hl);
        int h = eff_half(hl);
        int r = k % (220 * h);
        return r / (20 * h);
    endfunction

    function automatic logic [15:0] exp_code(int k, int hl);
        int h = eff_half(hl);
        int r = k % (220 * h);
        int a = r / (20 * h);
        int w = (r % (20 * h)) % (2 * h);
        logic [15:0] m = 16'(a);
        return (w >= h) ? (~m + 16'd1) : m;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input int hl);
        @(negedge clk);
        rst = 1'b1;
        sample_tick = 1'b0;
        half_len = 8'(hl);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        n_cap = 0; mon_bits = 0; mon_lew = 0; mon_shift = '0;
    endtask

    // one sample: tick, then check debug ports one clock later (R8)
    task automatic send_tick(input int k, input int hl);
        if (k > 0)
            check("R8", "dbg_code held before tick", dbg_code, exp_code(k - 1, hl));
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        check(exp_amp(k, hl) == 0 ? ((k >= 220 * eff_half(hl)) ? "R4" : "R2") : "R3",
              "dbg_code", dbg_code, exp_code(k, hl));
        check("R8", "dbg_amp", dbg_amp, exp_amp(k, hl));
        repeat (39) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset(1);
        check("R1", "ser_data after reset", ser_data, 0);
        check("R1", "ser_clk after reset", ser_clk, 0);
        check("R1", "ser_latch after reset", ser_latch, 0);
        check("R1", "dbg_code after reset", dbg_code, 0);
        check("R1", "dbg_amp after reset", dbg_amp, 0);
    endtask

    task automatic t_sweep(input int hl, input int nsmp);
        do_reset(hl);
        for (int k = 0; k < nsmp; k++) send_tick(k, hl);
        check("R7", "latch pulses per sample", n_cap, nsmp);
        for (int k = 0; k < nsmp && k < n_cap; k++) begin
            check(hl == 0 ? "R5" : "R6", "serial word", cap_word[k], exp_code(k, hl));
            check("R6", "bit clocks per frame", cap_bits[k], 16);
            check("R7", "latch width", cap_lew[k], 2);
        end
    endtask

    task automatic t_frame_timing();
        int t_first = -1;
        int t_le = -1;
        do_reset(1);
        repeat (20) send_tick(0, 1);   // stay in zero segment region
        do_reset(3);
        for (int k = 0; k < 60; k++) send_tick(k, 3);   // reach +1 level at sample 60
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
        check("R3", "+1 code with H=3", dbg_code, 16'h0001);
        for (int c = 1; c < 40; c++) begin
            @(negedge clk);
            if (ser_clk && t_first < 0) t_first = c;
            if (ser_latch && t_le < 0) t_le = c;
        end
        check("R8", "first ser_clk rise clock", t_first, 2);
        check("R8", "latch start clock", t_le, 33);
    endtask

    task automatic t_reset_mid();
        do_reset(1);
        for (int k = 0; k < 70; k++) send_tick(k, 1);
        check("R3", "mid-run amplitude", dbg_amp, 3);
        do_reset(1);
        for (int k = 0; k < 5; k++) send_tick(k, 1);
        check("R1", "restart frames", n_cap, 5);
        for (int k = 0; k < 5 && k < n_cap; k++)
            check("R1", "restart code zero", cap_word[k], 0);
    endtask

    task automatic t_extremes();
        do_reset(1);
        for (int k = 0; k < 221; k++) send_tick(k, 1);
        check("R4", "wrapped code", cap_word[220], 0);
        check("R3", "-10 code", cap_word[219], 16'hFFF6);
        check("R3", "+10 code", cap_word[218], 16'h000A);
        check("R3", "-1 code", cap_word[21], 16'hFFFF);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
    end

    initial begin
        t_reset_state();
        t_sweep(1, 230);
        t_sweep(2, 90);
        t_sweep(0, 50);
        t_frame_timing();
        t_reset_mid();
        t_extremes();
        summary();
    end

endmodule